// File: doc/BRIEF.md
# Lagged-Parity Checker with Stretched Error Flag

This block checks even parity over a registered data word. The parity bit for a word does not arrive with the word. It arrives on the clock after the word was captured. On each edge the block combines the captured word with the parity bit that is present now. It registers the result on a parity-out pin and drives an active-low error flag. Once the flag drops, it stays low for two clock cycles. The flag is cleared at once when reset is raised.

The block has two layouts. In the single layout all 25 data bits are checked by one stage, and that stage reports. In the paired layout only the low 14 bits count. Two identical stages are then cascaded. The first stage takes the parity input and performs the check. The second stage re-registers that result and drives the parity-out and error pins. The first stage's own error flag plays no part in that layout. This arrangement adds one clock of latency.

Top module: `lagpar_checker`

## Requirements
- R1: While `rst` is high, `err_n` reads 1 and `ppo` reads 0 in that same cycle, without waiting for a clock edge.
- R2: In the single layout (`pair_mode` = 0), suppose a word is captured at edge k and `par_in` is sampled at edge k+1. After edge k+1, `ppo` equals the XOR of all 25 word bits and that parity bit. The check is even parity, so `ppo` = 1 means a mismatch.
- R3: A mismatch reported on `ppo` drives `err_n` low during the two cycles that follow its edge. `err_n` returns high on the third edge unless a further mismatch occurs.
- R4: A mismatch that occurs while `err_n` is already low restarts the two-cycle window from the edge of that mismatch.
- R5: In the paired layout (`pair_mode` = 1), only data bits 13:0 enter the check. Bits 24:14 have no effect on `ppo` or `err_n`.
- R6: In the paired layout, `ppo` and `err_n` respond one edge later than in the single layout. For a word captured at edge k, the result appears after edge k+2.
- R7: Raising `rst` while `err_n` is low forces `err_n` high in the same cycle. After `rst` falls, no part of the cleared window reappears.
- R8: As long as every parity bit matches its word, `err_n` stays high and `ppo` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also masks the outputs combinationally |
| pair_mode | input | 1 | 0 selects the single 25-bit layout, 1 selects the paired 14-bit layout; change only under reset |
| data_in | input | 25 | Data word captured on each edge |
| par_in | input | 1 | Even-parity bit for the word captured on the previous edge |
| ppo | output | 1 | Registered check result; 1 on a mismatch |
| err_n | output | 1 | Active-low error flag, held low for two cycles after a mismatch |

## Verification
Two functions can fall in the same cycle. A new mismatch can land while an earlier two-cycle window is still running. A reset can arrive in the middle of a window. The first case is provoked by injecting wrong parity on back-to-back edges and on edges one apart. Judgement then rests on whether `err_n` remains low through exactly two cycles after the latest mismatch. The second case raises `rst` while the flag is low. The flag is then sampled within the same cycle to confirm it reads high, and again after reset falls to confirm the window does not resume.

// File: rtl/lagpar_pkg.sv
package lagpar_pkg;

    // Default geometry of the checker
    parameter int DFLT_DATA_W   = 25;
    parameter int DFLT_PAIR_W   = 14;
    parameter int DFLT_HOLD_CYC = 2;

    // Layout selection
    typedef enum logic {
        LAYOUT_SINGLE = 1'b0,
        LAYOUT_PAIR   = 1'b1
    } layout_e;

    // Per-stage result carried between stages and to the output mux
    typedef struct packed {
        logic mismatch;   // registered parity result (drives ppo)
        logic busy;       // error window active
    } stage_res_s;

    // Width of a counter that must hold values 0..n
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lagpar_hold.sv
module lagpar_hold #(
    parameter int HOLD_CYC = lagpar_pkg::DFLT_HOLD_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic busy
);
    localparam int CW = lagpar_pkg::cnt_bits(HOLD_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (trig) begin
            remain_q <= RELOAD;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);

endmodule

// File: rtl/lagpar_stage.sv
module lagpar_stage
    import lagpar_pkg::*;
#(
    parameter int DATA_W   = DFLT_DATA_W,
    parameter int HOLD_CYC = DFLT_HOLD_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] word,
    input  logic              par,
    output stage_res_s        res
);
    logic [DATA_W-1:0] word_q;
    logic              odd_now;
    logic              mism_q;
    logic              busy;

    // Capture the word; the parity for it comes one edge later
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word & mask;
        end
    end

    assign odd_now = (^word_q) ^ par;

    always_ff @(posedge clk) begin
        if (rst) begin
            mism_q <= 1'b0;
        end else begin
            mism_q <= odd_now;
        end
    end

    lagpar_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .trig (odd_now),
        .busy (busy)
    );

    always_comb begin
        res.mismatch = mism_q;
        res.busy     = busy;
    end

endmodule

// File: rtl/lagpar_checker.sv
module lagpar_checker
    import lagpar_pkg::*;
#(
    parameter int DATA_W   = DFLT_DATA_W,
    parameter int PAIR_W   = DFLT_PAIR_W,
    parameter int HOLD_CYC = DFLT_HOLD_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_mode,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    output logic              ppo,
    output logic              err_n
);
    localparam int NSTAGE = 2;
    localparam logic [DATA_W-1:0] MASK_FULL = '1;
    localparam logic [DATA_W-1:0] MASK_PAIR = MASK_FULL >> (DATA_W - PAIR_W);

    layout_e           layout;
    logic [DATA_W-1:0] sel_mask;
    stage_res_s        res [NSTAGE];
    stage_res_s        pick;

    assign layout   = layout_e'(pair_mode);
    assign sel_mask = (layout == LAYOUT_PAIR) ? MASK_PAIR : MASK_FULL;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            lagpar_stage #(.DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) u_stage (
                .clk  (clk),
                .rst  (rst),
                .mask (sel_mask),
                .word (data_in),
                .par  (par_in),
                .res  (res[g])
            );
        end else begin : g_tail
            // Downstream stage sees an empty word; its parity input is the
            // previous stage's registered result, so it re-times the check.
            lagpar_stage #(.DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) u_stage (
                .clk  (clk),
                .rst  (rst),
                .mask (MASK_FULL),
                .word ('0),
                .par  (res[g-1].mismatch),
                .res  (res[g])
            );
        end
    end

    assign pick  = (layout == LAYOUT_PAIR) ? res[NSTAGE-1] : res[0];
    assign ppo   = ~rst & pick.mismatch;
    assign err_n = rst | ~pick.busy;

endmodule

module lagpar_checker_sva (
    input logic clk,
    input logic rst,
    input logic ppo,
    input logic err_n
);
    // R1 / R7: reset masks outputs in the same cycle
    a_r1_reset_quiet: assert property (@(posedge clk) rst |-> (err_n && !ppo));

    // R3: the flag only drops together with a reported mismatch
    a_r3_fall_needs_mismatch: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |-> ppo);

    // R3: a reported mismatch always shows on the flag
    a_r3_mismatch_flags: assert property (@(posedge clk) disable iff (rst)
        ppo |-> !err_n);

    // R3: the window lasts at least two cycles
    a_r3_min_window: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |=> !err_n);

    // R3 / R8: no low flag without a mismatch within the last two cycles
    a_r8_window_bound: assert property (@(posedge clk) disable iff (rst)
        !err_n |-> (ppo || $past(ppo)));

    // R4: a mismatch inside the window restarts it
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        (ppo && $past(ppo)) |=> !err_n);
endmodule

bind lagpar_checker lagpar_checker_sva u_sva (
    .clk   (clk),
    .rst   (rst),
    .ppo   (ppo),
    .err_n (err_n)
);

// File: tb/lagpar_checker_bench.sv
`timescale 1ns/1ps
module lagpar_checker_bench;
    localparam int W  = 25;
    localparam int PW = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pair_mode = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         par_in = 1'b0;
    logic         ppo;
    logic         err_n;

    int n_checks = 0;
    int n_errors = 0;

    // Bench-side model state
    logic [W-1:0] m_prev = '0;
    logic         m_x1 = 1'b0;
    int           m_cnt = 0;
    logic         m_ppo = 1'b0;

    always #4 clk = ~clk;

    lagpar_checker u_lagpar_checker (
        .clk       (clk),
        .rst       (rst),
        .pair_mode (pair_mode),
        .data_in   (data_in),
        .par_in    (par_in),
        .ppo       (ppo),
        .err_n     (err_n)
    );

    initial begin
        repeat (50000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] cur_mask();
        return pair_mode ? ((1 << PW) - 1) : {W{1'b1}};
    endfunction

    function automatic logic [W-1:0] pat(input int i);
        logic [31:0] v;
        v = (i * 32'h9E3779B1) ^ (i << 7) ^ 32'h0155_AA33;
        return v[W-1:0];
    endfunction

    function automatic logic good_par();
        return ^(m_prev & cur_mask());
    endfunction

    // Called at a negedge: drive, clock, update model, check at next negedge
    task automatic step(input logic [W-1:0] d, input logic p,
                        input string tp, input string te);
        logic x;
        data_in = d;
        par_in  = p;
        @(posedge clk);
        x = (^(m_prev & cur_mask())) ^ p;
        if (pair_mode) begin
            m_ppo = m_x1;
            m_x1  = x;
        end else begin
            m_ppo = x;
        end
        if (m_ppo) m_cnt = 2;
        else if (m_cnt > 0) m_cnt--;
        m_prev = d;
        @(negedge clk);
        chk(tp, ppo, m_ppo);
        chk(te, err_n, (m_cnt == 0));
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        pair_mode = mode;
        data_in = '0;
        par_in = 1'b0;
        #1;
        chk("R1 err_n in reset", err_n, 1'b1);
        chk("R1 ppo in reset", ppo, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 err_n held in reset", err_n, 1'b1);
        chk("R1 ppo held in reset", ppo, 1'b0);
        m_prev = '0; m_x1 = 1'b0; m_cnt = 0; m_ppo = 1'b0;
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0);

        // R2 / R3: walking ones, every word odd; correct then wrong parity
        for (int i = 0; i < W; i++) step(W'(1) << i, good_par(), "R2", "R3");
        for (int i = 0; i < W; i++) step(W'(1) << i, 1'b0, "R2", "R3");
        for (int i = 0; i < 4; i++) step('0, good_par(), "R2", "R3");

        // R2 / R4: mixed words, injected isolated and back-to-back mismatches
        for (int i = 0; i < 150; i++) begin
            logic bad;
            bad = (i % 9 == 4) || (i % 9 == 5) || (i % 13 == 7);
            step(pat(i), good_par() ^ bad, "R2", "R4");
        end
        // R4: mismatches two edges apart
        for (int i = 0; i < 12; i++)
            step(pat(i + 300), good_par() ^ (i % 2 == 0), "R2", "R4");

        // R8: clean stream
        for (int i = 0; i < 4; i++) step('0, good_par(), "R8", "R8");
        for (int i = 0; i < 40; i++) step(pat(i + 500), good_par(), "R8", "R8");

        // R7: reset during an active window
        step(pat(900), good_par(), "R2", "R3");
        step(pat(901), ~good_par(), "R2", "R3");
        chk("R7 window active", err_n, 1'b0);
        rst = 1'b1;
        #1;
        chk("R7 err_n released by reset", err_n, 1'b1);
        chk("R7 ppo cleared by reset", ppo, 1'b0);
        @(posedge clk);
        @(negedge clk);
        m_prev = '0; m_x1 = 1'b0; m_cnt = 0; m_ppo = 1'b0;
        rst = 1'b0;
        for (int i = 0; i < 4; i++) step(pat(910 + i), good_par(), "R7", "R7");

        // Paired layout
        @(negedge clk);
        do_reset(1'b1);
        // R5: upper bits alone, parity 0: never a mismatch
        for (int i = PW; i < W; i++) step(W'(1) << i, 1'b0, "R5", "R5");
        for (int i = 0; i < 3; i++) step({W{1'b1}} << PW, 1'b0, "R5", "R5");
        // R5 / R6: low bits alone with parity 0: mismatch each, one edge later
        for (int i = 0; i < PW; i++) step(W'(1) << i, 1'b0, "R6", "R6");
        for (int i = 0; i < 4; i++) step('0, good_par(), "R6", "R6");
        // R6 / R4: mixed words with injected mismatches
        for (int i = 0; i < 150; i++) begin
            logic bad;
            bad = (i % 11 == 3) || (i % 11 == 4) || (i % 17 == 9);
            step(pat(i + 1000), good_par() ^ bad, "R6", "R4");
        end
        for (int i = 0; i < 20; i++) step(pat(i + 2000), good_par(), "R8", "R8");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule